// File: doc/BRIEF.md
# Indexed Display-Timing Register File with Write Lock

This block is the host-facing register store of a display timing controller. A host reaches every timing register through two ports. It first writes a register number into the index port, then reads or writes that register through the data port. A single 16-bit write to the index port can also do both steps in one transfer. The low byte selects the register and the high byte is stored into it on the same clock edge.

The block holds 25 byte-wide registers at indices 0x00 to 0x18. The ones the timing generator consumes are presented as parallel outputs:

- horizontal active end
- horizontal sync start
- vertical sync start
- vertical active end
- line pitch offset

Bit 7 of register 0x11 is a lock. While it is set, the horizontal group at indices 0x00 to 0x07 cannot be changed. Register 0x11 itself stays writable, so software can always clear the lock again.

Top module: `crtc_regfile`

## Requirements
- R1: After synchronous reset, the index is 0x00 and the registers hold these values: 0x01=0x4F, 0x04=0x55, 0x10=0xE9, 0x11=0x8C (locked), 0x12=0xDF, 0x13=0x50. Every other register holds 0x00.
- R2: A write with `port_sel`=0 and `byte_en`=01 loads `wr_data[7:0]` into the index. A read with `port_sel`=0 returns the index.
- R3: A write with `port_sel`=1 and `byte_en[0]`=1 stores `wr_data[7:0]` into the selected register. A read with `port_sel`=1 returns the selected register combinationally.
- R4: A write with `port_sel`=0 and `byte_en`=11 loads `wr_data[7:0]` into the index and stores `wr_data[15:8]` into the register at that new index, both on the same edge.
- R5: While bit 7 of register 0x11 is 1, writes to indices 0x00 to 0x07 leave those registers unchanged.
- R6: Register 0x11 accepts writes whether the lock is set or clear. Once bit 7 is cleared, indices 0x00 to 0x07 accept writes again. Indices 0x08 and above are never affected by the lock.
- R7: Data-port reads and writes leave the index unchanged.
- R8: An index of 0x19 or above reads as 0x00 through the data port, and writes to it change no register.
- R9: The parallel outputs always equal the stored registers:
  - `h_disp_end` = 0x01
  - `h_sync_start` = 0x04
  - `v_sync_start` = 0x10
  - `v_disp_end` = 0x12
  - `line_offset` = 0x13
  - `lock_on` = bit 7 of 0x11
- R10: A write whose `byte_en[0]` is 0 changes neither the index nor any register. The high byte of a data-port write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the current cycle |
| port_sel | input | 1 | 0 selects the index port, 1 selects the data port |
| byte_en | input | 2 | Byte lane enables for `wr_data` |
| wr_data | input | 16 | Write data; the high lane is used only by word writes to the index port |
| rd_data | output | 8 | Read value of the port chosen by `port_sel` |
| h_disp_end | output | 8 | Horizontal active end (0x01) |
| h_sync_start | output | 8 | Horizontal sync start (0x04) |
| v_sync_start | output | 8 | Vertical sync start (0x10) |
| v_disp_end | output | 8 | Vertical active end (0x12) |
| line_offset | output | 8 | Line pitch offset (0x13) |
| lock_on | output | 1 | Current state of the write lock |

## Verification
A wrong stored index shows up at once on an index-port read. It also shows up on the very next data-port access, as a read of the wrong register or a write landing in the wrong place. A wrong lock state shows up one cycle after the write it should have blocked or allowed: the guarded register either changes when it should not, or keeps its old value and `h_disp_end` or `h_sync_start` stays stale. A write leaking into a neighbouring register is visible one cycle later on the parallel outputs, or on the next read of that index. Every read and every parallel output is therefore compared against a model after each transfer.

// File: rtl/crtc_pkg.sv
package crtc_pkg;

    localparam int IDX_W    = 8;
    localparam int DATA_W   = 8;
    localparam int NREG     = 25;
    localparam int LOCK_BIT = 7;

    localparam logic [IDX_W-1:0] IDX_HDE   = 8'h01;
    localparam logic [IDX_W-1:0] IDX_HRS   = 8'h04;
    localparam logic [IDX_W-1:0] IDX_VRS   = 8'h10;
    localparam logic [IDX_W-1:0] IDX_LOCK  = 8'h11;
    localparam logic [IDX_W-1:0] IDX_VDE   = 8'h12;
    localparam logic [IDX_W-1:0] IDX_PITCH = 8'h13;
    localparam logic [IDX_W-1:0] GUARD_HI  = 8'h07;

    typedef enum logic {
        PORT_INDEX = 1'b0,
        PORT_DATA  = 1'b1
    } port_e;

    typedef struct packed {
        logic              en;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    function automatic logic [DATA_W-1:0] reset_value(logic [IDX_W-1:0] i);
        case (i)
            IDX_HDE:   return 8'h4F;
            IDX_HRS:   return 8'h55;
            IDX_VRS:   return 8'hE9;
            IDX_LOCK:  return 8'h8C;
            IDX_VDE:   return 8'hDF;
            IDX_PITCH: return 8'h50;
            default:   return '0;
        endcase
    endfunction

    function automatic logic is_guarded(logic [IDX_W-1:0] i);
        return i <= GUARD_HI;
    endfunction

endpackage

// File: rtl/crtc_bus_decode.sv
module crtc_bus_decode
    import crtc_pkg::*;
#(
    parameter int IW = IDX_W,
    parameter int DW = DATA_W
) (
    input  logic            wr_en,
    input  logic            port_sel,
    input  logic [1:0]      byte_en,
    input  logic [2*DW-1:0] wr_data,
    input  logic [IW-1:0]   cur_idx,
    output logic            idx_we,
    output logic [IW-1:0]   idx_nxt,
    output wr_req_t         req
);
    port_e port;
    logic  lo_lane;
    logic  word_op;

    always_comb begin
        port    = port_e'(port_sel);
        lo_lane = wr_en && byte_en[0];
        word_op = lo_lane && byte_en[1] && (port == PORT_INDEX);

        idx_we  = lo_lane && (port == PORT_INDEX);
        idx_nxt = wr_data[IW-1:0];

        req = '0;
        if (word_op) begin
            req.en   = 1'b1;
            req.idx  = wr_data[IW-1:0];
            req.data = wr_data[DW +: DW];
        end else if (lo_lane && port == PORT_DATA) begin
            req.en   = 1'b1;
            req.idx  = cur_idx;
            req.data = wr_data[DW-1:0];
        end
    end
endmodule

// File: rtl/crtc_index_reg.sv
module crtc_index_reg
    import crtc_pkg::*;
#(
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          idx_we,
    input  logic [IW-1:0] idx_nxt,
    output logic [IW-1:0] idx_q
);
    always_ff @(posedge clk) begin
        if (rst)         idx_q <= '0;
        else if (idx_we) idx_q <= idx_nxt;
    end

    p_index_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !idx_we |=> $stable(idx_q));
    p_index_load_r2: assert property (@(posedge clk) disable iff (rst)
        idx_we |=> idx_q == $past(idx_nxt));
endmodule

// File: rtl/crtc_reg_bank.sv
module crtc_reg_bank
    import crtc_pkg::*;
#(
    parameter int N  = NREG,
    parameter int DW = DATA_W
) (
    input  logic               clk,
    input  logic               rst,
    input  wr_req_t            req,
    output logic [N-1:0][DW-1:0] regs_q
);
    logic lock;
    assign lock = regs_q[int'(IDX_LOCK)][LOCK_BIT];

    for (genvar k = 0; k < N; k++) begin : g_reg
        localparam logic [IDX_W-1:0] KI = IDX_W'(k);
        logic hit;
        assign hit = req.en && (req.idx == KI) && !(is_guarded(KI) && lock);

        always_ff @(posedge clk) begin
            if (rst)      regs_q[k] <= reset_value(KI);
            else if (hit) regs_q[k] <= req.data;
        end

        if (k <= int'(GUARD_HI)) begin : g_guard
            p_guard_hold_r5: assert property (@(posedge clk) disable iff (rst)
                (req.en && req.idx == KI && lock) |=> $stable(regs_q[k]));
            p_guard_open_r6: assert property (@(posedge clk) disable iff (rst)
                (req.en && req.idx == KI && !lock) |=> regs_q[k] == $past(req.data));
        end else begin : g_free
            p_free_write_r6: assert property (@(posedge clk) disable iff (rst)
                (req.en && req.idx == KI) |=> regs_q[k] == $past(req.data));
        end
        p_untouched_r10: assert property (@(posedge clk) disable iff (rst)
            !(req.en && req.idx == KI) |=> $stable(regs_q[k]));
    end
endmodule

// File: rtl/crtc_read_mux.sv
module crtc_read_mux
    import crtc_pkg::*;
#(
    parameter int N  = NREG,
    parameter int IW = IDX_W,
    parameter int DW = DATA_W
) (
    input  logic                 port_sel,
    input  logic [IW-1:0]        idx_q,
    input  logic [N-1:0][DW-1:0] regs_q,
    output logic [DW-1:0]        rd_data
);
    logic [DW-1:0] sel_val;

    always_comb begin
        sel_val = '0;
        for (int k = 0; k < N; k++) begin
            if (idx_q == IW'(k)) sel_val = regs_q[k];
        end
        rd_data = (port_e'(port_sel) == PORT_DATA) ? sel_val : DW'(idx_q);
    end

    always_comb begin
        if (port_sel && int'(idx_q) >= N)
            p_empty_zero_r8: assert (rd_data == '0);
    end
endmodule

// File: rtl/crtc_regfile.sv
module crtc_regfile
    import crtc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        port_sel,
    input  logic [1:0]  byte_en,
    input  logic [15:0] wr_data,
    output logic [7:0]  rd_data,
    output logic [7:0]  h_disp_end,
    output logic [7:0]  h_sync_start,
    output logic [7:0]  v_sync_start,
    output logic [7:0]  v_disp_end,
    output logic [7:0]  line_offset,
    output logic        lock_on
);
    logic                          idx_we;
    logic [IDX_W-1:0]              idx_nxt;
    logic [IDX_W-1:0]              idx_q;
    wr_req_t                       req;
    logic [NREG-1:0][DATA_W-1:0]   regs_q;

    crtc_bus_decode u_dec (
        .wr_en    (wr_en),
        .port_sel (port_sel),
        .byte_en  (byte_en),
        .wr_data  (wr_data),
        .cur_idx  (idx_q),
        .idx_we   (idx_we),
        .idx_nxt  (idx_nxt),
        .req      (req)
    );

    crtc_index_reg u_idx (
        .clk     (clk),
        .rst     (rst),
        .idx_we  (idx_we),
        .idx_nxt (idx_nxt),
        .idx_q   (idx_q)
    );

    crtc_reg_bank u_bank (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .regs_q (regs_q)
    );

    crtc_read_mux u_rd (
        .port_sel (port_sel),
        .idx_q    (idx_q),
        .regs_q   (regs_q),
        .rd_data  (rd_data)
    );

    assign h_disp_end   = regs_q[int'(IDX_HDE)];
    assign h_sync_start = regs_q[int'(IDX_HRS)];
    assign v_sync_start = regs_q[int'(IDX_VRS)];
    assign v_disp_end   = regs_q[int'(IDX_VDE)];
    assign line_offset  = regs_q[int'(IDX_PITCH)];
    assign lock_on      = regs_q[int'(IDX_LOCK)][LOCK_BIT];

    p_word_both_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !port_sel && byte_en == 2'b11) |=> idx_q == $past(wr_data[7:0]));
    p_data_keeps_index_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && port_sel) |=> $stable(idx_q));
    p_reset_lock_r1: assert property (@(posedge clk)
        $past(rst) |-> (lock_on && h_disp_end == 8'h4F));
endmodule

// File: tb/sim_crtc_regfile.sv
module sim_crtc_regfile;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        port_sel = 1'b0;
    logic [1:0]  byte_en = 2'b00;
    logic [15:0] wr_data = '0;
    logic [7:0]  rd_data, h_disp_end, h_sync_start, v_sync_start, v_disp_end, line_offset;
    logic        lock_on;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [7:0] m_reg [256];
    logic [7:0] m_idx;

    always #5 clk = ~clk;

    crtc_regfile u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .port_sel(port_sel), .byte_en(byte_en),
        .wr_data(wr_data), .rd_data(rd_data), .h_disp_end(h_disp_end),
        .h_sync_start(h_sync_start), .v_sync_start(v_sync_start), .v_disp_end(v_disp_end),
        .line_offset(line_offset), .lock_on(lock_on)
    );

    function automatic logic [7:0] init_val(int i);
        case (i)
            8'h01: return 8'h4F;
            8'h04: return 8'h55;
            8'h10: return 8'hE9;
            8'h11: return 8'h8C;
            8'h12: return 8'hDF;
            8'h13: return 8'h50;
            default: return 8'h00;
        endcase
    endfunction

    function automatic bit may_write(logic [7:0] i, logic [7:0] lockreg);
        if (i >= 8'h19) return 1'b0;
        if (i <= 8'h07 && lockreg[7]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_outs(string req);
        check({req, "/R9 hde"},   h_disp_end,   m_reg[8'h01]);
        check({req, "/R9 hrs"},   h_sync_start, m_reg[8'h04]);
        check({req, "/R9 vrs"},   v_sync_start, m_reg[8'h10]);
        check({req, "/R9 vde"},   v_disp_end,   m_reg[8'h12]);
        check({req, "/R9 pitch"}, line_offset,  m_reg[8'h13]);
        check({req, "/R9 lock"},  {7'd0, lock_on}, {7'd0, m_reg[8'h11][7]});
    endtask

    task automatic do_write(logic sel, logic [1:0] be, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; port_sel = sel; byte_en = be; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; byte_en = 2'b00;
        if (be[0]) begin
            if (!sel) begin
                m_idx = d[7:0];
                if (be[1] && may_write(d[7:0], m_reg[8'h11])) m_reg[d[7:0]] = d[15:8];
            end else if (may_write(m_idx, m_reg[8'h11])) begin
                m_reg[m_idx] = d[7:0];
            end
        end
    endtask

    task automatic read_port(logic sel, output logic [7:0] v);
        port_sel = sel;
        #1 v = rd_data;
    endtask

    task automatic check_reads(string req);
        logic [7:0] v;
        read_port(1'b0, v); check({req, "/R2 index"}, v, m_idx);
        read_port(1'b1, v); check({req, "/R3 data"}, v, m_reg[m_idx]);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] guard_before;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 256; i++) m_reg[i] = (i < 25) ? init_val(i) : 8'h00;
        m_idx = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset contents
        check_outs("R1");
        check_reads("R1");
        for (int i = 0; i < 32; i++) begin
            do_write(1'b0, 2'b01, 16'(i));
            read_port(1'b1, v);
            check("R1 reset value / R8 empty", v, m_reg[i]);
        end

        // R5: locked after reset, guarded write ignored
        do_write(1'b0, 2'b11, 16'hAA01);
        check_outs("R5 locked word write");
        do_write(1'b0, 2'b01, 16'h0004);
        do_write(1'b1, 2'b01, 16'h0033);
        check("R5 hrs unchanged", h_sync_start, 8'h55);

        // R6: unlock via 0x11, then guarded writes land
        do_write(1'b0, 2'b11, 16'h0C11);
        check("R6 lock cleared", {7'd0, lock_on}, 8'd0);
        do_write(1'b0, 2'b11, 16'h4701);
        check("R6 hde written", h_disp_end, 8'h47);
        do_write(1'b0, 2'b11, 16'h5004);
        check("R4 hrs via word", h_sync_start, 8'h50);
        do_write(1'b0, 2'b11, 16'hAF12);
        do_write(1'b0, 2'b11, 16'hDA10);
        do_write(1'b0, 2'b11, 16'h4813);
        check_outs("R4 word writes");
        check_reads("R4 index after word");

        // R7: index kept across data accesses
        do_write(1'b1, 2'b01, 16'h0049);
        do_write(1'b1, 2'b01, 16'h004A);
        read_port(1'b0, v); check("R7 index kept", v, 8'h13);
        check("R7 last data", line_offset, 8'h4A);

        // R10: high-lane-only and data-port high byte
        do_write(1'b0, 2'b10, 16'h7705);
        read_port(1'b0, v); check("R10 no index change", v, 8'h13);
        do_write(1'b1, 2'b11, 16'hEE21);
        check("R10 high byte ignored", line_offset, 8'h21);

        // R6: relock, guarded blocked, 0x08+ still writable
        do_write(1'b0, 2'b11, 16'h8011);
        guard_before = h_disp_end;
        do_write(1'b0, 2'b11, 16'h1101);
        check("R5 relocked hde", h_disp_end, guard_before);
        do_write(1'b0, 2'b11, 16'h6612);
        check("R6 vde while locked", v_disp_end, 8'h66);

        // R8: empty index
        do_write(1'b0, 2'b11, 16'h5A19);
        read_port(1'b1, v); check("R8 empty read", v, 8'h00);
        do_write(1'b0, 2'b11, 16'hA5FF);
        read_port(1'b1, v); check("R8 top empty read", v, 8'h00);
        check_outs("R8 no spill");

        // Random mix
        for (int n = 0; n < 3000; n++) begin
            int op;
            logic [15:0] d;
            op = int'($urandom_range(0, 5));
            d  = 16'($urandom);
            if ($urandom_range(0, 3) != 0) d[7:0] = 8'($urandom_range(0, 31));
            case (op)
                0: do_write(1'b0, 2'b01, d);
                1, 2: do_write(1'b1, 2'($urandom_range(0, 3)), d);
                3: do_write(1'b0, 2'b11, d);
                4: do_write(1'b0, 2'b11, {8'($urandom) & 8'h80 | 8'h0C, 8'h11});
                default: do_write(1'b0, 2'($urandom_range(0, 3)), d);
            endcase
            check_outs("R5/R6 random");
            check_reads("R3/R7 random");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule